// File: doc/BRIEF.md
# Data Access Translation Checker

This block is the check stage for data loads and stores in a CPU memory pipeline. For each access it takes the virtual address, the access size (1, 2, 4 or 8 bytes), the direction, the current privilege level and the translation control bits. It decides whether the access passes through untranslated, must use the unified translation buffer, or faults. The hit, miss and multi-hit indications come from an external associative lookup, together with the matching entry's page number, page size, protection pair and dirty bit. The block turns these into either a physical address or a fault code, and gives each fault the exception event code and vector offset that the exception unit needs.

Store-queue addresses get their own treatment. Inside the store-queue window, data accesses are checked and passed through. The block also forms the write-back address the queue will use: a base register selected by address bit 5 when translation is off, or the translated page when it is on. On every qualified faulting access, the faulting virtual address is captured into a fault-address register, and its page-number bits are mirrored into the page-table-entry-high page-number field.

The block is purely combinational from request to result. Only the two fault capture registers are clocked.

Top module: `dtc_xlat_check`

## Requirements
- R1: Size code 0/1/2/3 means 1/2/4/8 bytes. An access whose address is not a multiple of its size gets fault code 5 (bad address). This check takes precedence over every other rule.
- R2: Store-queue window 0xE0000000–0xE3FFFFFF (address bits 31:26 = 111000). An aligned access here with address bits 1:0 non-zero gets fault 5. A user access while `sq_user_block` is 1 also gets fault 5. Any other access passes with pa = va and no fault, and the lookup inputs are ignored.
- R3: `sq_wb_addr` is the store-queue write-back address. With `xlat_en` = 0 it is `sq_base1` (if va bit 5 = 1) or `sq_base0`, plus va with bits 4:0 cleared. With `xlat_en` = 1 it is the translated address (R6) with bits 4:0 cleared.
- R4: A user-mode access (`user_mode` = 1) with va bit 31 set, outside the store-queue window, gets fault 5.
- R5: A privileged access to 0x7C000000–0x7FFFFFFF passes with pa = va. The same holds for any access when `xlat_en` = 0, or when va bits 31:29 are 4, 5 or 7. All of these cases ignore the lookup inputs.
- R6: Any other access uses the lookup. `lk_multi` = 1 gives fault 2. Otherwise `lk_hit` = 0 gives fault 1. On a hit, pa takes bits from `{lk_ppn, 10'b0}` above the page offset and from va below it. The page offset is 10, 12, 16 or 20 bits for `lk_pgsize` 0/1/2/3.
- R7: After a hit, the following give fault 3 (protected): a user access with `lk_prot` bit 1 clear, and a write with `lk_prot` bit 0 clear. A write to a writable page with `lk_dirty` = 0 gives fault 4 (first write).
- R8: Events, by fault code:
  - No fault, and fault 2: event 0x000 with vector 0x000.
  - Fault 1: event 0x060 on write and 0x040 on read, with vector 0x400.
  - Fault 3: event 0x0C0 on write and 0x0A0 on read.
  - Fault 4: event 0x080.
  - Fault 5: event 0x100 on write and 0x0E0 on read.
  - Faults 3, 4 and 5 all use vector 0x100.
  - `pa` is 0 whenever a fault is reported.
- R9: At a clock edge with `req_valid` = 1 and a non-zero fault, `fault_va` takes va and `pteh_vpn` takes va bits 31:10. At every other edge both registers hold their value.
- R10: After reset, `fault_va` and `pteh_vpn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access is real; qualifies fault capture |
| va | input | 32 | Virtual address |
| acc_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| is_write | input | 1 | 1 for a store |
| user_mode | input | 1 | 1 when the CPU is in user mode |
| xlat_en | input | 1 | Address translation enable |
| sq_user_block | input | 1 | Store queue restricted to privileged mode |
| sq_base0 | input | 32 | Write-back base for store queue 0 |
| sq_base1 | input | 32 | Write-back base for store queue 1 |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_multi | input | 1 | Lookup found more than one match |
| lk_ppn | input | 22 | Physical page number of the match |
| lk_pgsize | input | 2 | Page size code of the match |
| lk_prot | input | 2 | Protection pair (bit 1 user ok, bit 0 writable) |
| lk_dirty | input | 1 | Page already written |
| pa | output | 32 | Physical address, 0 on fault |
| sq_wb_addr | output | 32 | Store-queue write-back address |
| fault | output | 3 | Fault code 0..6 |
| evt_code | output | 12 | Exception event code |
| vec_off | output | 12 | Exception vector offset |
| fault_va | output | 32 | Last captured faulting address |
| pteh_vpn | output | 22 | Page-number field of entry-high register |

## Verification
Alignment and region rules can both apply to one access. The sweep provokes this with misaligned addresses inside the store-queue window, in the privileged pass-through window and in kernel space from user mode. In each case the result must be the bad-address code (R1) and not the region verdict. Permission and first-write rules also meet in a single lookup hit. Every protection pair is combined with both dirty values and both modes, and the bench checks that the user check and the write-protect check beat first-write. Each outcome is compared against an arithmetic model of the requirements.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_MISS     = 3'd1,
      FLT_MULTI    = 3'd2,
      FLT_PROT     = 3'd3,
      FLT_FIRSTWR  = 3'd4,
      FLT_BADADDR  = 3'd5,
      FLT_EXECPROT = 3'd6
   } fault_e;

   localparam logic [11:0] EV_MISS_WR = 12'h060;
   localparam logic [11:0] EV_MISS_RD = 12'h040;
   localparam logic [11:0] EV_PROT_WR = 12'h0C0;
   localparam logic [11:0] EV_PROT_RD = 12'h0A0;
   localparam logic [11:0] EV_FIRSTWR = 12'h080;
   localparam logic [11:0] EV_ADDR_WR = 12'h100;
   localparam logic [11:0] EV_ADDR_RD = 12'h0E0;
   localparam logic [11:0] VEC_MISS   = 12'h400;
   localparam logic [11:0] VEC_GEN    = 12'h100;
endpackage

// File: rtl/dtc_region.sv
module dtc_region
   import dtc_pkg::*;
#(
   parameter int VA_W = 32
) (
   input  logic [VA_W-1:0] va,
   input  logic [1:0]      acc_size,
   input  logic            user_mode,
   input  logic            xlat_en,
   input  logic            sq_user_block,
   output fault_e          pre_fault,
   output logic            need_lookup
);
   logic [2:0] size_mask;
   logic       misalign, in_sq, in_priv_win, bypass_top;

   always_comb begin
      case (acc_size)
         2'd0:    size_mask = 3'b000;
         2'd1:    size_mask = 3'b001;
         2'd2:    size_mask = 3'b011;
         default: size_mask = 3'b111;
      endcase
   end

   assign misalign    = |(va[2:0] & size_mask);
   assign in_sq       = (va[VA_W-1 -: 6] == 6'b111000);
   assign in_priv_win = (va[VA_W-1 -: 6] == 6'b011111);
   assign bypass_top  = (va[VA_W-1 -: 3] == 3'd4) || (va[VA_W-1 -: 3] == 3'd5) ||
                        (va[VA_W-1 -: 3] == 3'd7);

   always_comb begin
      pre_fault   = FLT_NONE;
      need_lookup = 1'b0;
      if (misalign) begin
         pre_fault = FLT_BADADDR;
      end else if (in_sq) begin
         if ((va[1:0] != 2'b00) || (sq_user_block && user_mode))
            pre_fault = FLT_BADADDR;
      end else if (user_mode && va[VA_W-1]) begin
         pre_fault = FLT_BADADDR;
      end else if (!user_mode && in_priv_win) begin
         pre_fault = FLT_NONE;
      end else if (!xlat_en || bypass_top) begin
         pre_fault = FLT_NONE;
      end else begin
         need_lookup = 1'b1;
      end
   end
endmodule

// File: rtl/dtc_perm.sv
module dtc_perm
   import dtc_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PG_MIN_BITS = 10,
   parameter int PG_SIZES    = 4,
   localparam int PPN_W      = VA_W - PG_MIN_BITS,
   localparam int SZ_W       = $clog2(PG_SIZES)
) (
   input  logic [VA_W-1:0]  va,
   input  logic             is_write,
   input  logic             user_mode,
   input  logic             lk_hit,
   input  logic             lk_multi,
   input  logic [PPN_W-1:0] lk_ppn,
   input  logic [SZ_W-1:0]  lk_pgsize,
   input  logic [1:0]       lk_prot,
   input  logic             lk_dirty,
   output fault_e           perm_fault,
   output logic [VA_W-1:0]  xlat_pa
);
   logic [VA_W-1:0] pg_mask [PG_SIZES];
   logic [VA_W-1:0] sel_mask;

   for (genvar g = 0; g < PG_SIZES; g++) begin : g_mask
      localparam int SH = PG_MIN_BITS + ((g == 0) ? 0 : (g == 1) ? 2 : (g == 2) ? 6 : 10);
      assign pg_mask[g] = {VA_W{1'b1}} << SH;
   end

   assign sel_mask = pg_mask[lk_pgsize];
   assign xlat_pa  = ({lk_ppn, {PG_MIN_BITS{1'b0}}} & sel_mask) | (va & ~sel_mask);

   always_comb begin
      if (lk_multi)                      perm_fault = FLT_MULTI;
      else if (!lk_hit)                  perm_fault = FLT_MISS;
      else if (user_mode && !lk_prot[1]) perm_fault = FLT_PROT;
      else if (is_write && !lk_prot[0])  perm_fault = FLT_PROT;
      else if (is_write && !lk_dirty)    perm_fault = FLT_FIRSTWR;
      else                               perm_fault = FLT_NONE;
   end
endmodule

// File: rtl/dtc_evmap.sv
module dtc_evmap
   import dtc_pkg::*;
#(
   parameter int EVT_W = 12
) (
   input  fault_e           flt,
   input  logic             is_write,
   output logic [EVT_W-1:0] evt_code,
   output logic [EVT_W-1:0] vec_off
);
   always_comb begin
      evt_code = '0;
      vec_off  = '0;
      case (flt)
         FLT_MISS: begin
            evt_code = EVT_W'(is_write ? EV_MISS_WR : EV_MISS_RD);
            vec_off  = EVT_W'(VEC_MISS);
         end
         FLT_PROT: begin
            evt_code = EVT_W'(is_write ? EV_PROT_WR : EV_PROT_RD);
            vec_off  = EVT_W'(VEC_GEN);
         end
         FLT_FIRSTWR: begin
            evt_code = EVT_W'(EV_FIRSTWR);
            vec_off  = EVT_W'(VEC_GEN);
         end
         FLT_BADADDR: begin
            evt_code = EVT_W'(is_write ? EV_ADDR_WR : EV_ADDR_RD);
            vec_off  = EVT_W'(VEC_GEN);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dtc_xlat_check.sv
module dtc_xlat_check
   import dtc_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PG_MIN_BITS = 10,
   parameter int PG_SIZES    = 4,
   parameter int EVT_W       = 12,
   localparam int PPN_W      = VA_W - PG_MIN_BITS,
   localparam int SZ_W       = $clog2(PG_SIZES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  va,
   input  logic [1:0]       acc_size,
   input  logic             is_write,
   input  logic             user_mode,
   input  logic             xlat_en,
   input  logic             sq_user_block,
   input  logic [VA_W-1:0]  sq_base0,
   input  logic [VA_W-1:0]  sq_base1,
   input  logic             lk_hit,
   input  logic             lk_multi,
   input  logic [PPN_W-1:0] lk_ppn,
   input  logic [SZ_W-1:0]  lk_pgsize,
   input  logic [1:0]       lk_prot,
   input  logic             lk_dirty,
   output logic [VA_W-1:0]  pa,
   output logic [VA_W-1:0]  sq_wb_addr,
   output logic [2:0]       fault,
   output logic [EVT_W-1:0] evt_code,
   output logic [EVT_W-1:0] vec_off,
   output logic [VA_W-1:0]  fault_va,
   output logic [PPN_W-1:0] pteh_vpn
);
   if (VA_W != 32)        begin : g_chk_va  $error("VA_W must be 32"); end
   if (PG_SIZES != 4)     begin : g_chk_pg  $error("PG_SIZES must be 4"); end
   if (PG_MIN_BITS < 6)   begin : g_chk_min $error("PG_MIN_BITS too small"); end
   if (EVT_W < 11)        begin : g_chk_evt $error("EVT_W too narrow"); end

   fault_e          pre_fault, perm_fault, fin_fault;
   logic            need_lookup;
   logic [VA_W-1:0] xlat_pa;

   dtc_region #(.VA_W(VA_W)) u_region (
      .va(va), .acc_size(acc_size), .user_mode(user_mode), .xlat_en(xlat_en),
      .sq_user_block(sq_user_block), .pre_fault(pre_fault), .need_lookup(need_lookup)
   );

   dtc_perm #(.VA_W(VA_W), .PG_MIN_BITS(PG_MIN_BITS), .PG_SIZES(PG_SIZES)) u_perm (
      .va(va), .is_write(is_write), .user_mode(user_mode), .lk_hit(lk_hit),
      .lk_multi(lk_multi), .lk_ppn(lk_ppn), .lk_pgsize(lk_pgsize), .lk_prot(lk_prot),
      .lk_dirty(lk_dirty), .perm_fault(perm_fault), .xlat_pa(xlat_pa)
   );

   assign fin_fault = need_lookup ? perm_fault : pre_fault;

   dtc_evmap #(.EVT_W(EVT_W)) u_evmap (
      .flt(fin_fault), .is_write(is_write), .evt_code(evt_code), .vec_off(vec_off)
   );

   assign fault = fin_fault;
   assign pa    = (fin_fault != FLT_NONE) ? '0 : (need_lookup ? xlat_pa : va);

   always_comb begin
      if (xlat_en) sq_wb_addr = {xlat_pa[VA_W-1:5], 5'b0};
      else         sq_wb_addr = (va[5] ? sq_base1 : sq_base0) + {va[VA_W-1:5], 5'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_va <= '0;
         pteh_vpn <= '0;
      end else if (req_valid && (fin_fault != FLT_NONE)) begin
         fault_va <= va;
         pteh_vpn <= va[VA_W-1:PG_MIN_BITS];
      end
   end

   AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_size == 2'd1 && va[0]) || (acc_size == 2'd2 && va[1:0] != 0) ||
       (acc_size == 2'd3 && va[2:0] != 0)) |-> fault == 3'd5); // R1
   AST_USER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && va[VA_W-1] && va[VA_W-1 -: 6] != 6'b111000) |-> fault == 3'd5); // R4
   AST_FW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fault == 3'd4) |-> is_write); // R7
   AST_MISS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (fault == 3'd1) |-> vec_off == EVT_W'(12'h400)); // R8
   AST_LATCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fault != 3'd0) |=> (fault_va == $past(va))); // R9
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && fault != 3'd0) |=> $stable(fault_va) && $stable(pteh_vpn)); // R9
endmodule

// File: tb/dtc_xlat_check_tb.sv
module dtc_xlat_check_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] va = '0;
   logic [1:0]  acc_size = '0;
   logic        is_write = 1'b0, user_mode = 1'b0, xlat_en = 1'b0, sq_user_block = 1'b0;
   logic [31:0] sq_base0 = 32'h1000_0000, sq_base1 = 32'h2200_0040;
   logic        lk_hit = 1'b0, lk_multi = 1'b0, lk_dirty = 1'b0;
   logic [21:0] lk_ppn = '0;
   logic [1:0]  lk_pgsize = '0, lk_prot = '0;
   logic [31:0] pa, sq_wb_addr, fault_va;
   logic [2:0]  fault;
   logic [11:0] evt_code, vec_off;
   logic [21:0] pteh_vpn;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dtc_xlat_check u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va), .acc_size(acc_size),
      .is_write(is_write), .user_mode(user_mode), .xlat_en(xlat_en),
      .sq_user_block(sq_user_block), .sq_base0(sq_base0), .sq_base1(sq_base1),
      .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_ppn(lk_ppn), .lk_pgsize(lk_pgsize),
      .lk_prot(lk_prot), .lk_dirty(lk_dirty), .pa(pa), .sq_wb_addr(sq_wb_addr),
      .fault(fault), .evt_code(evt_code), .vec_off(vec_off), .fault_va(fault_va),
      .pteh_vpn(pteh_vpn)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected model, built from the requirement text
   logic [2:0]  e_flt;
   logic [31:0] e_pa, e_wb;
   logic [11:0] e_evt, e_vec;
   string       e_tag;

   task automatic model();
      logic [31:0] m, tpa;
      int sh;
      bit lookup;
      sh  = (lk_pgsize == 0) ? 10 : (lk_pgsize == 1) ? 12 : (lk_pgsize == 2) ? 16 : 20;
      m   = 32'hFFFF_FFFF << sh;
      tpa = ({lk_ppn, 10'b0} & m) | (va & ~m);
      lookup = 1'b0;
      e_flt = 3'd0;
      if (((va & ((32'd1 << acc_size) - 1)) != 0)) begin e_flt = 3'd5; e_tag = "R1"; end
      else if (va[31:26] == 6'b111000) begin
         e_tag = "R2";
         if (va[1:0] != 0 || (sq_user_block && user_mode)) e_flt = 3'd5;
      end
      else if (user_mode && va[31]) begin e_flt = 3'd5; e_tag = "R4"; end
      else if (!user_mode && va[31:26] == 6'b011111) e_tag = "R5";
      else if (!xlat_en || va[31:29] == 4 || va[31:29] == 5 || va[31:29] == 7) e_tag = "R5";
      else begin
         lookup = 1'b1;
         e_tag = "R6";
         if (lk_multi) e_flt = 3'd2;
         else if (!lk_hit) e_flt = 3'd1;
         else begin
            e_tag = "R7";
            if (user_mode && !lk_prot[1]) e_flt = 3'd3;
            else if (is_write && !lk_prot[0]) e_flt = 3'd3;
            else if (is_write && !lk_dirty) e_flt = 3'd4;
         end
      end
      e_pa = (e_flt != 0) ? 32'd0 : (lookup ? tpa : va);
      e_wb = xlat_en ? (tpa & ~32'h1F) : ((va[5] ? sq_base1 : sq_base0) + (va & ~32'h1F));
      case (e_flt)
         3'd1: begin e_evt = is_write ? 12'h060 : 12'h040; e_vec = 12'h400; end
         3'd3: begin e_evt = is_write ? 12'h0C0 : 12'h0A0; e_vec = 12'h100; end
         3'd4: begin e_evt = 12'h080; e_vec = 12'h100; end
         3'd5: begin e_evt = is_write ? 12'h100 : 12'h0E0; e_vec = 12'h100; end
         default: begin e_evt = 12'h000; e_vec = 12'h000; end
      endcase
   endtask

   localparam logic [31:0] TOPS [10] = '{32'h0000_0000, 32'h6000_0000, 32'h7C00_0000,
      32'h7800_0000, 32'h8000_0000, 32'hA000_0000, 32'hC000_0000, 32'hE000_0000,
      32'hE400_0000, 32'hFC00_0000};

   initial begin
      #2;
      check(fault_va == 0 && pteh_vpn == 0, "R10", fault_va, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fault_va == 0, "R10", fault_va, 32'd0);

      // sweep: outputs are combinational, sampled 1 ns after each change
      for (int t = 0; t < 10; t++)
      for (int md = 0; md < 2; md++)
      for (int lo = 0; lo < 8; lo++)
      for (int sz = 0; sz < 4; sz++)
      for (int ctl = 0; ctl < 16; ctl++)
      for (int k = 0; k < 10; k++) begin
         va = TOPS[t] | (md[0] ? 32'h02AB_CDE0 : 32'h0123_4540) | 32'(lo);
         acc_size = 2'(sz);
         is_write = ctl[0]; user_mode = ctl[1]; xlat_en = ctl[2]; sq_user_block = ctl[3];
         lk_multi = (k == 1);
         lk_hit = (k >= 1);
         lk_prot = 2'(k - 2);
         lk_dirty = (k >= 6);
         lk_pgsize = 2'(k + lo);
         lk_ppn = 22'h155AA ^ 22'(k * 1031);
         #1;
         model();
         check(fault == e_flt, e_tag, 32'(fault), 32'(e_flt));
         check(pa == e_pa, e_tag, pa, e_pa);
         check(evt_code == e_evt && vec_off == e_vec, "R8", {evt_code, 4'h0, vec_off},
               {e_evt, 4'h0, e_vec});
         if (va[31:26] == 6'b111000)
            check(sq_wb_addr == e_wb, "R3", sq_wb_addr, e_wb);
         #1;
      end

      // fault capture
      @(negedge clk);
      va = 32'h1234_5672; acc_size = 2'd2; user_mode = 1'b0; req_valid = 1'b1;
      @(posedge clk); #1;
      check(fault_va == 32'h1234_5672, "R9", fault_va, 32'h1234_5672);
      check(pteh_vpn == 22'(32'h1234_5672 >> 10), "R9", 32'(pteh_vpn), 32'h1234_5672 >> 10);
      @(negedge clk);
      va = 32'h8000_1000; acc_size = 2'd0; xlat_en = 1'b0;
      @(posedge clk); #1;
      check(fault_va == 32'h1234_5672, "R9", fault_va, 32'h1234_5672);
      @(negedge clk);
      va = 32'h0000_0003; acc_size = 2'd3; req_valid = 1'b0;
      @(posedge clk); #1;
      check(fault_va == 32'h1234_5672, "R9", fault_va, 32'h1234_5672);
      @(negedge clk);
      req_valid = 1'b1; va = 32'hFFFF_FC01; acc_size = 2'd1;
      @(posedge clk); #1;
      check(fault_va == 32'hFFFF_FC01 && pteh_vpn == 22'h3FFFFF, "R9", fault_va, 32'hFFFF_FC01);
      req_valid = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule